// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This unit takes an integer read from a general-purpose register and produces the value a floating-point register should receive. The integer can be signed or unsigned, and 32 or 64 bits wide. The result is always written in 64-bit double format. In double mode it carries the value rounded to double precision. In single mode the value is first rounded to single precision and then widened exactly to a double.

Each request is qualified by `in_valid_i`. The result, the result-class code and the two rounding flags appear one clock later, marked by `out_valid_o`. A status update-enable tells the surrounding pipeline whether the class code and flags should be committed to floating-point status. It is low for the one case that can never round: a 32-bit source converted to a double. Condition-register writeback and exception trapping belong to the caller. The unit only passes on the record-request bit.

Top module: `i2f_convert`

## Requirements
- R1: `int_type_i` selects the source type: 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit, 3 = unsigned 64-bit. For 32-bit types, bits 63:32 of `src_i` have no effect on any output.
- R2: `prec_rec_i[1]` selects precision (0 = double, 1 = single). `prec_rec_i[0]` is returned on `rec_o` with the result.
- R3: When the source type is 32-bit and double is selected, `flag_we_o` is 0 and `frac_rnd_o` and `inexact_o` are 0. In every other case `flag_we_o` is 1.
- R4: Rounding follows `rmode_i`: 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward −infinity.
- R5: `inexact_o` is 1 exactly when the rounded value differs from the integer. `frac_rnd_o` is 1 exactly when rounding increased the magnitude.
- R6: In single mode, the result is the single-rounded value widened exactly to double. Its low 29 fraction bits are zero and its exponent is rebiased to the double bias of 1023.
- R7: A zero source gives +0.0 (all 64 bits zero) with class code 00010, whatever the type, precision or rounding mode.
- R8: The most negative signed value of either width converts to exactly −2^31 or −2^63 with no rounding flags set.
- R9: The class code is computed from the final rounded value: 00100 for positive normal, 01000 for negative normal, 00010 for positive zero.
- R10: A request accepted on a clock edge is presented on the outputs after that edge, with `out_valid_o` high for one cycle. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Request strobe |
| src_i | input | 64 | Integer operand |
| int_type_i | input | 2 | Source integer type |
| prec_rec_i | input | 2 | Bit 1: single mode; bit 0: record request |
| rmode_i | input | 2 | Rounding mode |
| out_valid_o | output | 1 | Result strobe |
| result_o | output | 64 | Double-format result |
| class_o | output | 5 | Result class code |
| frac_rnd_o | output | 1 | Magnitude was increased by rounding |
| inexact_o | output | 1 | Result is not exact |
| flag_we_o | output | 1 | Commit class and flags to status |
| rec_o | output | 1 | Record request passed through |

## Verification
The bench targets the following corner cases:
- **Rounding carries into the exponent.** Examples are all-ones 64-bit and 32-bit values, and 2^24 − 1 plus low bits in single mode. A design that drops the carry would return a value half as large.
- **Exact ties.** Values such as 2^24 + 1 and 2^24 + 3 in single mode, and 2^53 + 1 in double mode, are run under every rounding mode. A design that rounds ties away from zero, or treats the guard bit alone as inexact, fails here.
- **Signed minimum values and junk upper bits on 32-bit sources.** A design that negates in the wrong width, or that reads bits 63:32, produces a wrong sign or a wrong magnitude.
- **The exact 32-bit-to-double path.** A design that still raises the update-enable on this path is caught.

// File: rtl/i2f_pkg.sv
package i2f_pkg;

    localparam int XLEN   = 64;
    localparam int HALF   = XLEN / 2;
    localparam int DFRAC  = 52;
    localparam int SFRAC  = 23;
    localparam int DEXPW  = 11;
    localparam int DBIAS  = 1023;
    localparam int CNTW   = $clog2(XLEN) + 1;
    localparam int CLSW   = 5;

    typedef enum logic [1:0] {
        IT_S32 = 2'd0,
        IT_U32 = 2'd1,
        IT_S64 = 2'd2,
        IT_U64 = 2'd3
    } int_type_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_PINF = 2'd2,
        RM_NINF = 2'd3
    } rmode_e;

    localparam logic [CLSW-1:0] CLS_PZERO = 5'b00010;
    localparam logic [CLSW-1:0] CLS_PNORM = 5'b00100;
    localparam logic [CLSW-1:0] CLS_NNORM = 5'b01000;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] res;
        logic [CLSW-1:0] cls;
        logic            fr;
        logic            fi;
        logic            we;
        logic            rec;
    } i2f_out_t;

endpackage

// File: rtl/i2f_operand.sv
module i2f_operand
    import i2f_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] src_i,
    input  logic [1:0]   int_type_i,
    output logic [W-1:0] mag_o,
    output logic         neg_o,
    output logic         zero_o
);
    localparam int HW = W / 2;

    logic [W-1:0] ext;
    logic         sgn;
    int_type_e    ityp;

    always_comb begin
        ityp = int_type_e'(int_type_i);
        unique case (ityp)
            IT_S32: begin
                ext = {{HW{src_i[HW-1]}}, src_i[HW-1:0]};
                sgn = src_i[HW-1];
            end
            IT_U32: begin
                ext = {{HW{1'b0}}, src_i[HW-1:0]};
                sgn = 1'b0;
            end
            IT_S64: begin
                ext = src_i;
                sgn = src_i[W-1];
            end
            default: begin
                ext = src_i;
                sgn = 1'b0;
            end
        endcase
        // two's complement negate; the most negative value maps to its own
        // bit pattern, which read as unsigned is the correct magnitude
        mag_o  = sgn ? (~ext + 1'b1) : ext;
        neg_o  = sgn;
        zero_o = (ext == '0);
    end

endmodule

// File: rtl/i2f_lzc.sv
module i2f_lzc #(
    parameter int W  = 64,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    always_comb begin
        cnt_o = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) cnt_o = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/i2f_round.sv
module i2f_round #(
    parameter int W      = 64,
    parameter int FRAC_W = 52
) (
    input  logic [W-1:0]      norm_i,
    input  logic              neg_i,
    input  logic [1:0]        rmode_i,
    output logic [FRAC_W-1:0] frac_o,
    output logic              carry_o,
    output logic              inc_o,
    output logic              inexact_o
);
    import i2f_pkg::*;

    localparam int GPOS = W - 2 - FRAC_W;

    logic [FRAC_W-1:0] keep;
    logic              guard;
    logic              sticky;
    logic [FRAC_W:0]   sum;
    rmode_e            rm;

    always_comb begin
        rm     = rmode_e'(rmode_i);
        keep   = norm_i[W-2 -: FRAC_W];
        guard  = norm_i[GPOS];
        sticky = |norm_i[GPOS-1:0];
        unique case (rm)
            RM_NEAR: inc_o = guard & (sticky | keep[0]);
            RM_ZERO: inc_o = 1'b0;
            RM_PINF: inc_o = (guard | sticky) & ~neg_i;
            default: inc_o = (guard | sticky) & neg_i;
        endcase
        inexact_o = guard | sticky;
        sum       = {1'b0, keep} + {{FRAC_W{1'b0}}, inc_o};
        carry_o   = sum[FRAC_W];
        frac_o    = sum[FRAC_W-1:0];
    end
endmodule

// File: rtl/i2f_convert.sv
module i2f_convert
    import i2f_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        in_valid_i,
    input  logic [63:0] src_i,
    input  logic [1:0]  int_type_i,
    input  logic [1:0]  prec_rec_i,
    input  logic [1:0]  rmode_i,
    output logic        out_valid_o,
    output logic [63:0] result_o,
    output logic [4:0]  class_o,
    output logic        frac_rnd_o,
    output logic        inexact_o,
    output logic        flag_we_o,
    output logic        rec_o
);
    localparam logic [DEXPW-1:0] TOP_EXP = DEXPW'(DBIAS + XLEN - 1);
    localparam int               PADW    = DFRAC - SFRAC;

    logic [XLEN-1:0]  mag;
    logic             neg;
    logic             zero;
    logic [CNTW-1:0]  lz;
    logic [XLEN-1:0]  norm;

    logic [DFRAC-1:0] d_frac;
    logic             d_carry, d_inc, d_inx;
    logic [SFRAC-1:0] s_frac;
    logic             s_carry, s_inc, s_inx;

    i2f_out_t r_d, r_q;

    i2f_operand #(.W(XLEN)) u_opnd (
        .src_i      (src_i),
        .int_type_i (int_type_i),
        .mag_o      (mag),
        .neg_o      (neg),
        .zero_o     (zero)
    );

    i2f_lzc #(.W(XLEN), .CW(CNTW)) u_lzc (
        .vec_i (mag),
        .cnt_o (lz)
    );

    assign norm = mag << lz;

    i2f_round #(.W(XLEN), .FRAC_W(DFRAC)) u_rnd_dbl (
        .norm_i    (norm),
        .neg_i     (neg),
        .rmode_i   (rmode_i),
        .frac_o    (d_frac),
        .carry_o   (d_carry),
        .inc_o     (d_inc),
        .inexact_o (d_inx)
    );

    i2f_round #(.W(XLEN), .FRAC_W(SFRAC)) u_rnd_sgl (
        .norm_i    (norm),
        .neg_i     (neg),
        .rmode_i   (rmode_i),
        .frac_o    (s_frac),
        .carry_o   (s_carry),
        .inc_o     (s_inc),
        .inexact_o (s_inx)
    );

    always_comb begin
        logic             single;
        logic             exact_path;
        logic             carry;
        logic [DEXPW-1:0] exp_b;
        logic [DFRAC-1:0] frac;

        r_d       = r_q;
        r_d.valid = 1'b0;

        single     = prec_rec_i[1];
        exact_path = ~int_type_i[1] & ~single;
        carry      = single ? s_carry : d_carry;
        frac       = single ? {s_frac, {PADW{1'b0}}} : d_frac;
        exp_b      = TOP_EXP - DEXPW'(lz) + DEXPW'(carry);

        if (in_valid_i) begin
            r_d.valid = 1'b1;
            r_d.rec   = prec_rec_i[0];
            r_d.we    = ~exact_path;
            if (zero) begin
                r_d.res = '0;
                r_d.cls = CLS_PZERO;
                r_d.fr  = 1'b0;
                r_d.fi  = 1'b0;
            end else begin
                r_d.res = {neg, exp_b, frac};
                r_d.cls = neg ? CLS_NNORM : CLS_PNORM;
                r_d.fr  = ~exact_path & (single ? s_inc : d_inc);
                r_d.fi  = ~exact_path & (single ? s_inx : d_inx);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign out_valid_o = r_q.valid;
    assign result_o    = r_q.res;
    assign class_o     = r_q.cls;
    assign frac_rnd_o  = r_q.fr;
    assign inexact_o   = r_q.fi;
    assign flag_we_o   = r_q.we;
    assign rec_o       = r_q.rec;

    // R10: one-cycle latency
    a_r10_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);

    // R3: exact 32-bit to double path never requests a status update
    a_r3_exact_no_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && !int_type_i[1] && !prec_rec_i[1])
            |=> (!flag_we_o && !frac_rnd_o && !inexact_o));

    // R3: all other paths do request one
    a_r3_rounding_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && (int_type_i[1] || prec_rec_i[1])) |=> flag_we_o);

    // R5: a magnitude increase is always inexact
    a_r5_fr_inexact: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && frac_rnd_o) |-> inexact_o);

    // R6: single results carry no precision beyond 24 bits
    a_r6_single_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && prec_rec_i[1]) |=> (result_o[PADW-1:0] == '0));

    // R9: exactly one class bit, and its sign agrees with the result
    a_r9_class_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> ($countones(class_o) == 1));
    a_r9_class_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> (result_o[63] == class_o[3]));

    // R2: record bit returned with the result
    a_r2_rec_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> (rec_o == $past(prec_rec_i[0])));

endmodule

// File: tb/i2f_convert_test.sv
module i2f_convert_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] src = '0;
    logic [1:0]  ityp = '0;
    logic [1:0]  prec = '0;
    logic [1:0]  rm = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [4:0]  cls;
    logic        fr, fi, we, rec;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    i2f_convert uut (
        .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .src_i(src),
        .int_type_i(ityp), .prec_rec_i(prec), .rmode_i(rm),
        .out_valid_o(out_valid), .result_o(result), .class_o(cls),
        .frac_rnd_o(fr), .inexact_o(fi), .flag_we_o(we), .rec_o(rec)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            finish_run();
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h (src=%h it=%0d pr=%0d rm=%0d)",
                     tag, act, exp, src, ityp, prec, rm);
        end
    endtask

    // reference computed by exact remainder comparison against one half ulp
    function automatic void model(input logic [63:0] s, input logic [1:0] it,
                                  input logic [1:0] pr, input logic [1:0] md,
                                  output logic [63:0] r, output logic [4:0] c,
                                  output logic f_r, output logic f_i, output logic w);
        logic [63:0] v, q, rem, half;
        logic ng, up;
        int p, pw, sh, mq;
        w  = !(!it[1] && !pr[1]);
        ng = 1'b0;
        case (it)
            2'd0: begin v = {{32{s[31]}}, s[31:0]}; ng = s[31]; end
            2'd1: v = {32'h0, s[31:0]};
            2'd2: begin v = s; ng = s[63]; end
            default: v = s;
        endcase
        if (ng) v = -v;
        if (v == 0) begin
            r = '0; c = 5'b00010; f_r = 0; f_i = 0;
            return;
        end
        p = 63;
        while (!v[p]) p--;
        pw = pr[1] ? 24 : 53;
        up = 1'b0;
        rem = '0;
        if (p < pw) begin
            q = v; mq = p;
        end else begin
            sh   = p - (pw - 1);
            q    = v >> sh;
            rem  = v & ((64'd1 << sh) - 64'd1);
            half = 64'd1 << (sh - 1);
            case (md)
                2'd0: up = (rem > half) || (rem == half && q[0]);
                2'd1: up = 1'b0;
                2'd2: up = (rem != 0) && !ng;
                default: up = (rem != 0) && ng;
            endcase
            q = q + {63'd0, up};
            mq = pw - 1;
            if (q[pw]) begin q = q >> 1; p++; end
        end
        q = q << (52 - mq);
        r = {ng, 11'(1023 + p), q[51:0]};
        c = ng ? 5'b01000 : 5'b00100;
        f_r = up;
        f_i = (rem != 0);
    endfunction

    task automatic run(input logic [63:0] s, input logic [1:0] it,
                       input logic [1:0] pr, input logic [1:0] md);
        logic [63:0] er;
        logic [4:0]  ec;
        logic efr, efi, ewe;
        model(s, it, pr, md, er, ec, efr, efi, ewe);
        @(negedge clk);
        src = s; ityp = it; prec = pr; rm = md; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 out_valid", {63'd0, out_valid}, 64'd1);
        chk(pr[1] ? "R6/R4/R1 result" : "R4/R1 result", result, er);
        chk("R9 class", {59'd0, cls}, {59'd0, ec});
        chk("R5 fraction-rounded", {63'd0, fr}, {63'd0, efr});
        chk("R5 inexact", {63'd0, fi}, {63'd0, efi});
        chk("R3 flag update-enable", {63'd0, we}, {63'd0, ewe});
        chk("R2 record bit", {63'd0, rec}, {63'd0, pr[0]});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset valid", {63'd0, out_valid}, 64'd0);
        chk("R10 reset result", result, 64'd0);
        chk("R10 reset we", {63'd0, we}, 64'd0);
        rst_n = 1'b1;

        // R7: zero in every type, precision and mode
        for (int k = 0; k < 16; k++) begin
            run(64'd0, 2'(k), 2'(k >> 2), 2'(k + 1));
            chk("R7 zero result", result, 64'd0);
            chk("R7 zero class", {59'd0, cls}, 64'd2);
        end
        // R1: 32-bit types ignore upper bits (zero low word with junk above)
        run(64'hDEAD_BEEF_0000_0000, 2'd0, 2'd2, 2'd0);
        chk("R1 upper bits ignored", result, 64'd0);
        // R8: signed minimum values
        run(64'h1234_5678_8000_0000, 2'd0, 2'd0, 2'd0);
        chk("R8 s32 min", result, 64'hC1E0_0000_0000_0000);
        run(64'h8000_0000_0000_0000, 2'd2, 2'd0, 2'd3);
        chk("R8 s64 min", result, 64'hC3E0_0000_0000_0000);
        chk("R8 s64 min exact", {63'd0, fi}, 64'd0);
        // exponent carry and ties under all rounding modes
        for (int m = 0; m < 4; m++) begin
            run(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 2'd0, 2'(m));
            run(64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 2'd2, 2'(m));
            run(64'h0000_0000_FFFF_FFFF, 2'd1, 2'd3, 2'(m));
            run(64'h0000_0000_0100_0001, 2'd0, 2'd2, 2'(m));
            run(64'h0000_0000_0100_0003, 2'd0, 2'd2, 2'(m));
            run(64'hFFFF_FFFF_FEFF_FFFD, 2'd2, 2'd3, 2'(m));
            run(64'h0020_0000_0000_0001, 2'd2, 2'd0, 2'(m));
            run(64'h0020_0000_0000_0003, 2'd3, 2'd1, 2'(m));
            run(64'h0000_0000_7FFF_FFFF, 2'd0, 2'd0, 2'(m));
        end
        // R4: directed tie-to-even value for single
        run(64'h0000_0000_0100_0001, 2'd1, 2'd2, 2'd0);
        chk("R4 tie to even down", result, 64'h4170_0000_0000_0000);

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [63:0] s;
            int sel;
            sel = $urandom % 4;
            case (sel)
                0: s = {$urandom, $urandom};
                1: s = {$urandom, 32'(($urandom % 2000))};
                2: s = {$urandom, $urandom} >> ($urandom % 64);
                default: s = 64'd0 - 64'(($urandom % 5000)) ;
            endcase
            run(s, 2'($urandom), 2'($urandom), 2'($urandom));
        end

        @(negedge clk);
        chk("R10 valid single cycle", {63'd0, out_valid}, 64'd0);
        finish_run();
    end

endmodule